// File: doc/BRIEF.md
# Delta-Panel Horizontal Start Pulse Router

This block places the horizontal start pulse for two panel-driver output sets, A and B, once per display line. A pixel counter restarts on every line-start strobe. For each output set the block works out which horizontal scan direction that set serves and which vertical direction is in use, then looks at the line parity and the aspect mode. From these it picks a start position relative to the programmed video-start count. The panel's pixels sit in a delta arrangement, so the position needs half-clock resolution. The block emits the pulse either on a rising clock edge or half a clock later.

Set A serves the direction selected by the right/left input, and set B always serves the mirrored horizontal direction. A mirrored panel can therefore run beside a normal one. The block also provides an inverted copy of the right/left flag for the mirrored panel. The direction and aspect inputs are captured only at line start, so a pulse already scheduled for the current line is never disturbed. All pins are plain level or strobe controls; there is no streaming data path, so no valid/ready handshake applies.

Top module: `hst_router`

## Requirements
- R1: While reset is asserted and after its release, before the first line-start strobe, `hst_a` and `hst_b` stay low.
- R2: `xrgt` is always the logical inverse of `rgt`.
- R3: Set A uses right-scan placement when `rgt` is 1 and left-scan placement when `rgt` is 0. Set B always uses the opposite horizontal direction to set A.
- R4: `dwn` = 1 selects down-scan placement and `dwn` = 0 selects up-scan placement, for both sets.
- R5: With `aspect_wide` = 1 (16:9), the offset from video start in clocks is as follows. It is −2 when down-scan is on an odd line or up-scan is on an even line. Otherwise it is −3.5 for right scan and −0.5 for left scan.
- R6: With `aspect_wide` = 0 (4:3), the same three cases use −5, −6.5 and −3.5 clocks.
- R7: A `frame_start` strobe makes the next line odd, and so does a line-start strobe in the same cycle as `frame_start`. Every other line-start strobe flips the parity.
- R8: A pulse rises `1 + vstart + offset` clock periods after the clock edge that samples `line_start`. A fractional offset puts the rise on the falling edge. The pulse is high for exactly one clock period, once per line.
- R9: `rgt`, `dwn` and `aspect_wide` are sampled only on the line-start edge. Changing them mid-line does not move or cut that line's pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| frame_start | input | 1 | One-cycle strobe; the next line is odd |
| vstart | input | CNT_W | Video-start position in clocks after line start |
| aspect_wide | input | 1 | 1 = 16:9, 0 = 4:3 |
| rgt | input | 1 | 1 = set A scans right, 0 = set A scans left |
| dwn | input | 1 | 1 = down scan, 0 = up scan |
| hst_a | output | 1 | Start pulse for output set A |
| hst_b | output | 1 | Start pulse for output set B |
| xrgt | output | 1 | Inverse of `rgt` for the mirrored panel |

## Verification
The pulse-width and one-per-line properties assume `vstart` is at least 8. They also assume consecutive line-start strobes are further apart than the latest pulse position. Under these conditions the computed position is never negative and a pulse never overlaps the next line strobe. The stimulus holds `vstart` at 20 and spaces strobes 41 clocks apart, which leaves a wide margin past the latest pulse. Control inputs change only a few nanoseconds after a rising edge, so the line-start capture never sees them in transition.

// File: rtl/hst_pkg.sv
package hst_pkg;

  typedef struct packed {
    logic right;
    logic down;
    logic odd;
    logic wide;
  } hst_mode_t;

  localparam int OFS_W = 6;

  // Offset from video start in half-clock units (always negative).
  function automatic logic signed [OFS_W-1:0] half_offset(hst_mode_t m);
    logic base_grp;
    base_grp = (m.down == m.odd);
    if (m.wide) begin
      if (base_grp)     half_offset = -6'sd4;
      else if (m.right) half_offset = -6'sd7;
      else              half_offset = -6'sd1;
    end else begin
      if (base_grp)     half_offset = -6'sd10;
      else if (m.right) half_offset = -6'sd13;
      else              half_offset = -6'sd7;
    end
  endfunction

endpackage

// File: rtl/hst_line_ctx.sv
module hst_line_ctx #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             frame_start,
  input  logic             rgt,
  input  logic             dwn,
  input  logic             wide,
  output logic [CNT_W-1:0] cnt,
  output logic             rgt_l,
  output logic             dwn_l,
  output logic             wide_l,
  output logic             odd_l
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= CNT_MAX;
    end else if (line_start) begin
      cnt <= '0;
    end else if (cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgt_l  <= 1'b1;
      dwn_l  <= 1'b1;
      wide_l <= 1'b1;
    end else if (line_start) begin
      rgt_l  <= rgt;
      dwn_l  <= dwn;
      wide_l <= wide;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odd_l <= 1'b0;
    end else if (line_start) begin
      odd_l <= frame_start ? 1'b1 : ~odd_l;
    end else if (frame_start) begin
      odd_l <= 1'b0;
    end
  end

  // R7: parity alternates between lines inside a frame
  a_r7_parity_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !frame_start) |=> (odd_l != $past(odd_l)));

  // R7: a line opened together with frame start is odd
  a_r7_frame_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && frame_start) |=> odd_l);

  // R9: captured controls move only on a line-start edge
  a_r9_hold_mid_line: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable({rgt_l, dwn_l, wide_l}));

endmodule

// File: rtl/hst_lane.sv
module hst_lane
  import hst_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] vstart,
  input  hst_mode_t        mode,
  output logic             hst
);
  localparam int POS_W = CNT_W + 2;

  logic signed [POS_W-1:0] pos2;
  logic [CNT_W-1:0]        tgt;
  logic                    half;
  logic                    hit;
  logic                    pos_q;
  logic                    neg_q;

  always_comb begin
    pos2 = $signed({1'b0, vstart, 1'b0})
         + POS_W'(half_offset(mode));
    tgt  = pos2[CNT_W:1];
    half = pos2[0];
    hit  = !pos2[POS_W-1] && (cnt == tgt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= 1'b0;
    else        pos_q <= hit;
  end

  // Half-clock retiming stage for the .5 offsets
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_q <= 1'b0;
    else        neg_q <= pos_q;
  end

  assign hst = half ? neg_q : pos_q;

  logic [1:0] pulse_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pulse_cnt <= 2'd0;
    else if (line_start)        pulse_cnt <= 2'd0;
    else if (pos_q && pulse_cnt != 2'd3) pulse_cnt <= pulse_cnt + 2'd1;
  end

  // R8: the falling-edge copy trails the rising-edge pulse by half a clock
  a_r8_half_stage: assert property (@(posedge clk) disable iff (!rst_n)
    neg_q == pos_q);

  // R8: one clock wide
  a_r8_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q |=> !pos_q);

  // R8: at most one pulse per line
  a_r8_one_per_line: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= 2'd1);

endmodule

// File: rtl/hst_router.sv
module hst_router
  import hst_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             frame_start,
  input  logic [CNT_W-1:0] vstart,
  input  logic             aspect_wide,
  input  logic             rgt,
  input  logic             dwn,
  output logic             hst_a,
  output logic             hst_b,
  output logic             xrgt
);
  localparam int N_SETS = 2;

  logic [CNT_W-1:0] cnt;
  logic             rgt_l, dwn_l, wide_l, odd_l;
  logic [N_SETS-1:0] hst_v;

  hst_line_ctx #(.CNT_W(CNT_W)) u_ctx (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_start  (line_start),
    .frame_start (frame_start),
    .rgt         (rgt),
    .dwn         (dwn),
    .wide        (aspect_wide),
    .cnt         (cnt),
    .rgt_l       (rgt_l),
    .dwn_l       (dwn_l),
    .wide_l      (wide_l),
    .odd_l       (odd_l)
  );

  for (genvar g = 0; g < N_SETS; g++) begin : g_set
    hst_mode_t m;
    // set 0 follows the right/left input, set 1 mirrors it
    assign m = '{right: (g == 0) ? rgt_l : ~rgt_l,
                 down:  dwn_l,
                 odd:   odd_l,
                 wide:  wide_l};
    hst_lane #(.CNT_W(CNT_W)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_start (line_start),
      .cnt        (cnt),
      .vstart     (vstart),
      .mode       (m),
      .hst        (hst_v[g])
    );
  end

  assign hst_a = hst_v[0];
  assign hst_b = hst_v[1];
  assign xrgt  = ~rgt;

  // R1: no pulse before the first line starts
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == {CNT_W{1'b1}}) |-> (hst_a == 1'b0 && hst_b == 1'b0));

endmodule

// File: tb/tb_hst_router.sv
`timescale 1ns/1ps
module tb_hst_router;
  localparam int CNT_W = 11;
  localparam int LC    = 40;
  localparam int VS    = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start = 1'b0, frame_start = 1'b0;
  logic [CNT_W-1:0] vstart = CNT_W'(VS);
  logic aspect_wide = 1'b1, rgt = 1'b1, dwn = 1'b1;
  logic hst_a, hst_b, xrgt;

  int checks = 0, errors = 0;
  bit exp_odd = 1'b0;
  bit done = 1'b0;

  typedef struct {int idx_a; int idx_b; bit r; string tag;} exp_t;
  exp_t sb[$];
  event line_go;

  always #10 clk = ~clk;

  hst_router #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .frame_start(frame_start), .vstart(vstart),
    .aspect_wide(aspect_wide), .rgt(rgt), .dwn(dwn),
    .hst_a(hst_a), .hst_b(hst_b), .xrgt(xrgt));

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Offset in half clocks, from R5/R6
  function automatic int ofs2(bit right, bit down, bit odd, bit wide);
    bit base = (down && odd) || (!down && !odd);
    if (wide) return base ? -4 : (right ? -7 : -1);
    return base ? -10 : (right ? -13 : -7);
  endfunction

  // First-high sample index: rise 1+vstart+offset clocks after E0 (R8)
  function automatic int exp_idx(bit right, bit down, bit odd, bit wide);
    return 2 * VS + ofs2(right, down, odd, wide) + 2;
  endfunction

  task automatic run_line(bit r, bit d, bit w, bit fs, bit flip, string tag);
    exp_t e;
    @(posedge clk); #2;
    rgt = r; dwn = d; aspect_wide = w;
    line_start = 1'b1; frame_start = fs;
    exp_odd = fs ? 1'b1 : ~exp_odd;
    e.idx_a = exp_idx(r, d, exp_odd, w);   // R3: set A follows rgt
    e.idx_b = exp_idx(~r, d, exp_odd, w);  // R3: set B mirrored
    e.r = r; e.tag = tag;
    sb.push_back(e);
    @(posedge clk); #2;
    line_start = 1'b0; frame_start = 1'b0;
    -> line_go;
    for (int i = 0; i < LC - 1; i++) begin
      @(posedge clk);
      if (flip && i == 3) begin
        #2; rgt = ~r; dwn = ~d; aspect_wide = ~w;  // R9 mid-line change
      end
    end
  endtask

  // Monitor: scoreboard pop and compare
  initial begin
    forever begin
      exp_t e;
      int fa, fb, na, nb;
      @(line_go);
      e = sb.pop_front();
      fa = -1; fb = -1; na = 0; nb = 0;
      #3;
      check(xrgt == ~e.r, "R2 xrgt", xrgt, ~e.r);
      for (int s = 0; s < 2 * LC; s++) begin
        if (hst_a) begin na++; if (fa < 0) fa = s; end
        if (hst_b) begin nb++; if (fb < 0) fb = s; end
        if (s != 2 * LC - 1) #10;
      end
      check(fa == e.idx_a, {e.tag, " R8 set A position"}, fa, e.idx_a);
      check(fb == e.idx_b, {e.tag, " R8 set B position"}, fb, e.idx_b);
      check(na == 2, {e.tag, " R8 set A width"}, na, 2);
      check(nb == 2, {e.tag, " R8 set B width"}, nb, 2);
    end
  end

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check(hst_a == 1'b0 && hst_b == 1'b0, "R1 reset low", hst_a + hst_b, 0);
    #2 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #5;
    check(hst_a == 1'b0 && hst_b == 1'b0, "R1 idle low", hst_a + hst_b, 0);
    rgt = 1'b0; #1;
    check(xrgt == 1'b1, "R2 xrgt idle", xrgt, 1);
    // Sweep R3 R4 R5 R6 R7: every rgt/dwn/aspect with odd then even line
    for (int c = 0; c < 8; c++) begin
      run_line(c[0], c[1], c[2], 1'b1, 1'b0, "R5 R6 sweep odd");
      run_line(c[0], c[1], c[2], 1'b0, 1'b0, "R5 R6 sweep even");
    end
    // R7: third line odd again, then frame_start alone resets parity
    run_line(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R7 third line");
    @(posedge clk); #2 frame_start = 1'b1;
    @(posedge clk); #2 frame_start = 1'b0;
    exp_odd = 1'b0;
    run_line(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 after frame");
    // R9: controls flipped mid-line keep the latched placement
    run_line(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R9 flip wide");
    run_line(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R9 flip narrow");
    repeat (4) @(posedge clk);
    done = 1'b1;
    check(sb.size() == 0, "R8 scoreboard drained", sb.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule